// File: doc/BRIEF.md
# Row-Hit-First Request Scheduler

This block chooses which pending request of one memory channel goes out next. The queue is presented as parallel per-entry fields: a valid bit, a rank, a bank, a row and an order tag. A smaller order tag means an older request. The block keeps its own table of open rows, with one slot per bank. A slot is addressed as rank times banks-per-rank plus bank. Each slot also holds a counter of accesses made since the row was last activated. From the queue and the table, the block registers one selection per cycle. The selection gives the entry index and says whether the bank needs an activate, and whether it first needs a precharge.

One configuration input picks the ordering. In strict order the oldest valid request always wins. In row-hit order a request whose row is already open in its bank beats any older request that misses. A second input picks the page policy. Open-page leaves the row open after an access, and close-page closes the bank after each access. A consumer pulses `issue` to accept the registered selection, and the open-row table is updated on that pulse. A row that reaches the access cap is closed. This bounds how long hits to that row can starve older misses.

Top module: `sched_rowhit_picker`

## Requirements
- R1: With no valid entry the registered `sel_vld` is 0; the selection registers the queue sampled at the previous rising edge, so a change in `q_vld` shows on `sel_vld` after exactly one edge.
- R2: With `cfg_rowhit`=0 the valid entry with the smallest order tag is selected, whatever the open-row state.
- R3: With `cfg_rowhit`=1, an entry whose bank slot is open on the same row (a hit) wins over older misses; among several hits the one with the smallest order tag wins.
- R4: With `cfg_rowhit`=1 and no hit in the queue, the valid entry with the smallest order tag is selected.
- R5: `sel_act`=1 exactly when the selected entry is not a hit; `sel_pre`=1 exactly when its bank slot is open on a different row, so `sel_pre` implies `sel_act`.
- R6: With `cfg_closepage`=0, an accepted access leaves its row open, so a later request to that bank and row is a hit (`sel_act`=0).
- R7: With `cfg_closepage`=1, an accepted access closes its bank slot, so a later request to the same row shows `sel_act`=1, `sel_pre`=0.
- R8: After `ROW_CAP` accesses (default 16) to a row since its activation, the row is closed; later requests to it are no longer hits, so the oldest request wins and the row's request shows `sel_act`=1, `sel_pre`=0.
- R9: The per-bank access count restarts at 1 whenever a row is activated, allowing a further `ROW_CAP` accesses before the next forced close.
- R10: `issue` while `sel_vld`=0 has no effect on the open-row table.
- R11: After reset every bank slot is closed and `sel_vld`=0.
- R12: Bank slots are independent: an open row in one slot makes no request to another slot (another rank or bank) a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rowhit | input | 1 | 1 = row-hit-first order, 0 = strict age order |
| cfg_closepage | input | 1 | 1 = close bank after each access, 0 = keep row open |
| q_vld | input | N | Per-entry valid |
| q_rank | input | N*RK_W | Per-entry rank, entry i at bits [i*RK_W +: RK_W] |
| q_bank | input | N*BK_W | Per-entry bank within rank |
| q_row | input | N*ROW_W | Per-entry row |
| q_age | input | N*ORD_W | Per-entry order tag, smaller is older |
| issue | input | 1 | Consumer accepts the registered selection |
| sel_vld | output | 1 | A selection is present |
| sel_idx | output | IDX_W | Index of the selected entry |
| sel_act | output | 1 | Selected entry needs an activate |
| sel_pre | output | 1 | Selected entry needs a precharge before the activate |

## Verification
The hardest state to reach is the forced close. A row must be accepted `ROW_CAP` times in a row, while an older miss waits behind it and keeps asking to win. The bench parks a permanent hit and an older miss in the queue. It accepts the hit repeatedly and checks the winner on every pass, until the count runs out and the miss takes over. After that it reopens the row and repeats the run, to show that the count restarts. A long pseudo-random sweep over both orderings and both page policies then compares every selection with an arithmetic model in the bench. The sweep uses few rows, so hits, misses with precharge, and closed banks all occur often.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    ORDER_STRICT = 1'b0,
    ORDER_ROWHIT = 1'b1
  } order_mode_e;

  // Flat bank slot number of a (rank, bank) pair.
  function automatic int bank_slot(int rank, int bank, int banks_per_rank);
    return rank * banks_per_rank + bank;
  endfunction

  // Access count after one more access: continues on a hit, restarts on activation.
  function automatic int next_run(logic hit, int run);
    return hit ? run + 1 : 1;
  endfunction

  function automatic logic run_exhausted(int run, int cap);
    return run >= cap;
  endfunction

  function automatic logic keep_open(logic closepage, int run, int cap);
    return !closepage && !run_exhausted(run, cap);
  endfunction

endpackage

// File: rtl/sched_bank_table.sv
module sched_bank_table #(
  parameter int NB    = 8,
  parameter int ROW_W = 8,
  parameter int CAP   = 16,
  parameter int CNT_W = 5,
  parameter int BID_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [BID_W-1:0]      upd_bid,
  input  logic [ROW_W-1:0]      upd_row,
  input  logic                  closepage,
  output logic [NB-1:0]         open_vec,
  output logic [NB*ROW_W-1:0]   row_flat,
  output logic [NB*CNT_W-1:0]   cnt_flat,
  output logic [NB-1:0]         act_evt,
  output logic [NB-1:0]         cap_evt
);
  import sched_pkg::*;

  for (genvar b = 0; b < NB; b++) begin : g_slot
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    logic [CNT_W-1:0] cnt_r;
    logic             sel_b;
    logic             hit_b;
    int               run_nxt;
    logic             stay;

    assign sel_b = upd && (upd_bid == BID_W'(b));
    assign hit_b = open_r && (row_r == upd_row);

    always_comb begin
      run_nxt = next_run(hit_b, int'(cnt_r));
      stay    = keep_open(closepage, run_nxt, CAP);
    end

    assign act_evt[b] = sel_b && !hit_b;
    assign cap_evt[b] = sel_b && !closepage && run_exhausted(run_nxt, CAP);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        row_r  <= '0;
        cnt_r  <= '0;
      end else if (sel_b) begin
        open_r <= stay;
        row_r  <= upd_row;
        cnt_r  <= CNT_W'(run_nxt);
      end
    end

    assign open_vec[b]                  = open_r;
    assign row_flat[b*ROW_W +: ROW_W]   = row_r;
    assign cnt_flat[b*CNT_W +: CNT_W]   = cnt_r;
  end

endmodule

// File: rtl/sched_hit_map.sv
module sched_hit_map #(
  parameter int N     = 8,
  parameter int NB    = 8,
  parameter int ROW_W = 8,
  parameter int BID_W = 3
) (
  input  logic [N*BID_W-1:0]  ent_bid,
  input  logic [N*ROW_W-1:0]  ent_row,
  input  logic [NB-1:0]       open_vec,
  input  logic [NB*ROW_W-1:0] row_flat,
  output logic [N-1:0]        hit_vec,
  output logic [N-1:0]        pre_vec
);
  logic [ROW_W-1:0] open_row [NB];

  for (genvar b = 0; b < NB; b++) begin : g_rows
    assign open_row[b] = row_flat[b*ROW_W +: ROW_W];
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [BID_W-1:0] bid;
    logic [ROW_W-1:0] row;
    logic             same;
    assign bid        = ent_bid[i*BID_W +: BID_W];
    assign row        = ent_row[i*ROW_W +: ROW_W];
    assign same       = (open_row[bid] == row);
    assign hit_vec[i] = open_vec[bid] && same;
    assign pre_vec[i] = open_vec[bid] && !same;
  end

endmodule

// File: rtl/sched_oldest.sv
module sched_oldest #(
  parameter int N     = 8,
  parameter int ORD_W = 4,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]       cand,
  input  logic [N*ORD_W-1:0] age,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [ORD_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || (age[i*ORD_W +: ORD_W] < best))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = age[i*ORD_W +: ORD_W];
      end
    end
  end

endmodule

// File: rtl/sched_rowhit_picker.sv
module sched_rowhit_picker #(
  parameter int N       = 8,
  parameter int RANKS   = 2,
  parameter int BANKS   = 4,
  parameter int ROW_W   = 8,
  parameter int ORD_W   = 4,
  parameter int ROW_CAP = 16,
  localparam int RK_W   = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BK_W   = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rowhit,
  input  logic               cfg_closepage,
  input  logic [N-1:0]       q_vld,
  input  logic [N*RK_W-1:0]  q_rank,
  input  logic [N*BK_W-1:0]  q_bank,
  input  logic [N*ROW_W-1:0] q_row,
  input  logic [N*ORD_W-1:0] q_age,
  input  logic               issue,
  output logic               sel_vld,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_act,
  output logic               sel_pre
);
  import sched_pkg::*;

  localparam int NB    = RANKS * BANKS;
  localparam int BID_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int CNT_W = $clog2(ROW_CAP + 1);

  // Per-entry bank slot
  logic [N*BID_W-1:0] ent_bid;
  logic [BID_W-1:0]   ent_bid_a [N];
  logic [ROW_W-1:0]   ent_row_a [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign ent_bid[i*BID_W +: BID_W] =
      BID_W'(bank_slot(int'(q_rank[i*RK_W +: RK_W]), int'(q_bank[i*BK_W +: BK_W]), BANKS));
    assign ent_bid_a[i] = ent_bid[i*BID_W +: BID_W];
    assign ent_row_a[i] = q_row[i*ROW_W +: ROW_W];
  end

  // Open-row table
  logic [NB-1:0]       open_vec;
  logic [NB*ROW_W-1:0] row_flat;
  logic [NB*CNT_W-1:0] cnt_flat;
  logic [NB-1:0]       act_evt;
  logic [NB-1:0]       cap_evt;
  logic                issue_fire;
  logic [BID_W-1:0]    sel_bid_q;
  logic [ROW_W-1:0]    sel_row_q;

  assign issue_fire = issue && sel_vld;

  sched_bank_table #(
    .NB(NB), .ROW_W(ROW_W), .CAP(ROW_CAP), .CNT_W(CNT_W), .BID_W(BID_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (issue_fire),
    .upd_bid  (sel_bid_q),
    .upd_row  (sel_row_q),
    .closepage(cfg_closepage),
    .open_vec (open_vec),
    .row_flat (row_flat),
    .cnt_flat (cnt_flat),
    .act_evt  (act_evt),
    .cap_evt  (cap_evt)
  );

  // Hit classification
  logic [N-1:0] hit_vec;
  logic [N-1:0] pre_vec;

  sched_hit_map #(
    .N(N), .NB(NB), .ROW_W(ROW_W), .BID_W(BID_W)
  ) u_hits (
    .ent_bid (ent_bid),
    .ent_row (q_row),
    .open_vec(open_vec),
    .row_flat(row_flat),
    .hit_vec (hit_vec),
    .pre_vec (pre_vec)
  );

  // Candidate set and age pick
  order_mode_e  mode;
  logic [N-1:0] hits_live;
  logic         use_hits;
  logic [N-1:0] cand;
  logic         pick_found;
  logic [IDX_W-1:0] pick_idx;

  assign mode      = order_mode_e'(cfg_rowhit);
  assign hits_live = hit_vec & q_vld;
  assign use_hits  = (mode == ORDER_ROWHIT) && (|hits_live);
  assign cand      = use_hits ? hits_live : q_vld;

  sched_oldest #(
    .N(N), .ORD_W(ORD_W), .IDX_W(IDX_W)
  ) u_pick (
    .cand (cand),
    .age  (q_age),
    .found(pick_found),
    .idx  (pick_idx)
  );

  // Registered selection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_vld   <= 1'b0;
      sel_idx   <= '0;
      sel_act   <= 1'b0;
      sel_pre   <= 1'b0;
      sel_bid_q <= '0;
      sel_row_q <= '0;
    end else begin
      sel_vld   <= pick_found;
      sel_idx   <= pick_idx;
      sel_act   <= pick_found && !hit_vec[pick_idx];
      sel_pre   <= pick_found && pre_vec[pick_idx];
      sel_bid_q <= ent_bid_a[pick_idx];
      sel_row_q <= ent_row_a[pick_idx];
    end
  end

endmodule

// File: rtl/sched_rowhit_checker.sv
module sched_rowhit_checker #(
  parameter int N     = 8,
  parameter int NB    = 8,
  parameter int IDX_W = 3,
  parameter int BID_W = 3,
  parameter int CNT_W = 5,
  parameter int CAP   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_closepage,
  input logic               issue,
  input logic [N-1:0]       q_vld,
  input logic               sel_vld,
  input logic [IDX_W-1:0]   sel_idx,
  input logic               sel_act,
  input logic               sel_pre,
  input logic               issue_fire,
  input logic [BID_W-1:0]   sel_bid_q,
  input logic [NB-1:0]      open_vec,
  input logic [NB*CNT_W-1:0] cnt_flat,
  input logic [NB-1:0]      act_evt,
  input logic [NB-1:0]      cap_evt
);
  logic [N-1:0]     vld_seen;
  logic [CNT_W-1:0] cnt_a [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_seen <= '0;
    else        vld_seen <= q_vld;
  end

  for (genvar b = 0; b < NB; b++) begin : g_cnt
    assign cnt_a[b] = cnt_flat[b*CNT_W +: CNT_W];

    assert_open_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      open_vec[b] |-> (cnt_a[b] >= 1) && (int'(cnt_a[b]) < CAP));
  end

  assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld == '0) |=> !sel_vld);

  assert_pick_was_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> vld_seen[sel_idx]);

  assert_pre_needs_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pre |-> sel_act);

  assert_act_matches_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (sel_act == act_evt[sel_bid_q]));

  assert_closepage_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && cfg_closepage) |=> !open_vec[$past(sel_bid_q)]);

  assert_cap_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_evt) |=> !open_vec[$past(sel_bid_q)]);

  assert_run_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && sel_act) |=> (cnt_a[$past(sel_bid_q)] == CNT_W'(1)));

  assert_idle_issue_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !sel_vld) |=> $stable(open_vec));

endmodule

bind sched_rowhit_picker sched_rowhit_checker #(
  .N(N), .NB(NB), .IDX_W(IDX_W), .BID_W(BID_W), .CNT_W(CNT_W), .CAP(ROW_CAP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_closepage(cfg_closepage),
  .issue        (issue),
  .q_vld        (q_vld),
  .sel_vld      (sel_vld),
  .sel_idx      (sel_idx),
  .sel_act      (sel_act),
  .sel_pre      (sel_pre),
  .issue_fire   (issue_fire),
  .sel_bid_q    (sel_bid_q),
  .open_vec     (open_vec),
  .cnt_flat     (cnt_flat),
  .act_evt      (act_evt),
  .cap_evt      (cap_evt)
);

// File: tb/tb_sched_rowhit_picker.sv
module tb_sched_rowhit_picker;
  localparam int N     = 8;
  localparam int RANKS = 2;
  localparam int BANKS = 4;
  localparam int ROW_W = 8;
  localparam int ORD_W = 4;
  localparam int CAP   = 16;
  localparam int RK_W  = 1;
  localparam int BK_W  = 2;
  localparam int IDX_W = 3;
  localparam int NB    = RANKS * BANKS;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_rowhit = 1'b1;
  logic               cfg_closepage = 1'b0;
  logic [N-1:0]       q_vld = '0;
  logic [N*RK_W-1:0]  q_rank = '0;
  logic [N*BK_W-1:0]  q_bank = '0;
  logic [N*ROW_W-1:0] q_row = '0;
  logic [N*ORD_W-1:0] q_age = '0;
  logic               issue = 1'b0;
  logic               sel_vld;
  logic [IDX_W-1:0]   sel_idx;
  logic               sel_act;
  logic               sel_pre;

  int checks = 0;
  int errors = 0;

  // bench model of the open-row table
  int m_open [NB];
  int m_row  [NB];
  int m_cnt  [NB];
  int e_rank [N];
  int e_bank [N];
  int e_row  [N];
  int e_age  [N];

  always #10 clk = ~clk;

  sched_rowhit_picker #(
    .N(N), .RANKS(RANKS), .BANKS(BANKS), .ROW_W(ROW_W), .ORD_W(ORD_W), .ROW_CAP(CAP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_rowhit(cfg_rowhit), .cfg_closepage(cfg_closepage),
    .q_vld(q_vld), .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row), .q_age(q_age),
    .issue(issue), .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_act(sel_act), .sel_pre(sel_pre)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    step();
    step();
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic clear_q();
    q_vld = '0;
  endtask

  task automatic put(int i, int rk, int bk, int row, int age);
    q_vld[i] = 1'b1;
    q_rank[i*RK_W +: RK_W]  = RK_W'(rk);
    q_bank[i*BK_W +: BK_W]  = BK_W'(bk);
    q_row[i*ROW_W +: ROW_W] = ROW_W'(row);
    q_age[i*ORD_W +: ORD_W] = ORD_W'(age);
    e_rank[i] = rk; e_bank[i] = bk; e_row[i] = row; e_age[i] = age;
  endtask

  task automatic accept();
    issue = 1'b1;
    step();
    issue = 1'b0;
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_q();
    step();
    step();
    rst_n = 1'b1;
    step();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_cnt[b] = 0;
    end
  endtask

  function automatic int slot_of(int i);
    return e_rank[i] * BANKS + e_bank[i];
  endfunction

  function automatic int model_hit(int i);
    return (m_open[slot_of(i)] != 0 && m_row[slot_of(i)] == e_row[i]) ? 1 : 0;
  endfunction

  // oldest candidate found by walking order tags upward
  function automatic int model_pick(int want_hit);
    for (int a = 0; a < (1 << ORD_W); a++)
      for (int i = 0; i < N; i++)
        if (q_vld[i] && e_age[i] == a && (want_hit == 0 || model_hit(i) == 1))
          return i;
    return -1;
  endfunction

  task automatic model_accept(int i);
    int s;
    s = slot_of(i);
    m_cnt[s] = (model_hit(i) == 1) ? m_cnt[s] + 1 : 1;
    m_row[s] = e_row[i];
    m_open[s] = (cfg_closepage == 1'b0 && m_cnt[s] < CAP) ? 1 : 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lcg;
    int exp_i;
    @(negedge clk);
    do_reset();

    // R11: reset state
    chk("R11 sel_vld after reset", int'(sel_vld), 0);

    // R10: accept with nothing selected must not open bank slot 0, row 0
    accept();
    put(0, 0, 0, 0, 0);
    settle();
    chk("R10 idle issue left slot closed act", int'(sel_act), 1);
    chk("R10 idle issue left slot closed pre", int'(sel_pre), 0);
    chk("R11 slot closed initially", int'(sel_vld), 1);

    // open rank0 bank0 row0 (count 1)
    accept();
    clear_q();
    put(0, 1, 0, 0, 0);
    settle();
    chk("R12 other rank same bank not hit act", int'(sel_act), 1);
    chk("R12 other rank same bank pre", int'(sel_pre), 0);
    clear_q();
    put(0, 0, 0, 0, 0);
    settle();
    chk("R6 open page row stays open act", int'(sel_act), 0);
    chk("R6 hit has no pre", int'(sel_pre), 0);
    clear_q();
    put(0, 0, 0, 9, 0);
    settle();
    chk("R5 conflict act", int'(sel_act), 1);
    chk("R5 conflict pre", int'(sel_pre), 1);

    // R3 / R2 / R4 ordering
    clear_q();
    put(0, 0, 1, 3, 0);
    put(1, 0, 0, 9, 1);
    put(2, 0, 0, 0, 3);
    put(3, 0, 0, 0, 2);
    settle();
    chk("R3 oldest hit beats older miss", int'(sel_idx), 3);
    chk("R3 hit act", int'(sel_act), 0);
    cfg_rowhit = 1'b0;
    settle();
    chk("R2 strict order picks oldest", int'(sel_idx), 0);
    chk("R2 strict order act", int'(sel_act), 1);
    cfg_rowhit = 1'b1;
    q_vld[2] = 1'b0;
    q_vld[3] = 1'b0;
    put(0, 0, 1, 3, 5);
    settle();
    chk("R4 no hit picks oldest", int'(sel_idx), 1);

    // R8: cap of consecutive hits, older miss waiting
    clear_q();
    put(0, 0, 3, 1, 0);
    put(1, 0, 0, 0, 1);
    settle();
    for (int k = 2; k <= CAP; k++) begin
      chk($sformatf("R8 hit wins access %0d", k), int'(sel_idx), 1);
      accept();
    end
    chk("R8 after cap oldest wins", int'(sel_idx), 0);
    q_vld[0] = 1'b0;
    settle();
    chk("R8 capped row needs act", int'(sel_act), 1);
    chk("R8 capped row no pre", int'(sel_pre), 0);
    accept();
    put(0, 0, 3, 1, 0);
    settle();
    for (int k = 2; k <= CAP; k++) begin
      chk($sformatf("R9 count restarted access %0d", k), int'(sel_idx), 1);
      accept();
    end
    chk("R9 second cap oldest wins", int'(sel_idx), 0);

    // R7: close page
    cfg_closepage = 1'b1;
    clear_q();
    put(0, 1, 2, 4, 0);
    settle();
    accept();
    chk("R7 close page act", int'(sel_act), 1);
    chk("R7 close page pre", int'(sel_pre), 0);
    cfg_closepage = 1'b0;

    // R1: empty queue and one-edge registration
    clear_q();
    settle();
    chk("R1 empty queue", int'(sel_vld), 0);
    put(2, 0, 1, 1, 0);
    chk("R1 not yet registered", int'(sel_vld), 0);
    step();
    chk("R1 registered after one edge", int'(sel_vld), 1);
    clear_q();
    step();
    chk("R1 empty after one edge", int'(sel_vld), 0);

    // sweep against the bench model
    do_reset();
    lcg = 32'h1234_5678;
    for (int it = 0; it < 400; it++) begin
      cfg_rowhit    = (it % 3) != 0;
      cfg_closepage = (it % 11) == 5;
      clear_q();
      for (int i = 0; i < N; i++) begin
        lcg = lcg * 1103515245 + 12345;
        if (((lcg >>> 16) & 3) != 0)
          put(i, (lcg >>> 18) & 1, (lcg >>> 20) & 3, (lcg >>> 23) & 3, (i * 5 + it) & 7);
      end
      settle();
      exp_i = -1;
      if (cfg_rowhit) exp_i = model_pick(1);
      if (exp_i < 0) exp_i = model_pick(0);
      chk("R1 sweep valid", int'(sel_vld), (exp_i >= 0) ? 1 : 0);
      if (exp_i >= 0) begin
        chk(cfg_rowhit ? "R3 sweep index" : "R2 sweep index", int'(sel_idx), exp_i);
        chk("R5 sweep act", int'(sel_act), 1 - model_hit(exp_i));
        chk("R5 sweep pre", int'(sel_pre),
            (m_open[slot_of(exp_i)] != 0 && model_hit(exp_i) == 0) ? 1 : 0);
        model_accept(exp_i);
        accept();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule